// File: doc/BRIEF.md
# Socket Status-Change Interrupt Controller

This block watches the status lines of one card socket and turns changes on them into a management interrupt. Five asynchronous pins are sampled: battery-dead/status-change, battery-warning, ready, and the two card-detect lines. Each pin is synchronized, and any change of level between two consecutive synchronized samples sets a sticky bit in a four-bit status register. The two card-detect pins share one status bit.

An eight-bit configuration register holds one enable per status bit and a four-bit routing number. When any status bit is set and enabled, the block drives a registered interrupt output. This output is sixteen lines wide and one-hot, and the routing number picks the line. Routing number zero parks the interrupt, so no line is driven. In I/O card interface mode the battery-warning and ready enables are ignored. Status bits clear when software writes 1 to them.

A synchronous software power-state reset clears the status register. It also clears the configuration, unless the wake-enable input is high. In that case the configuration is kept.

Top module: `sock_irq_ctrl`

## Requirements
- R1: After `rst_n` is low, the configuration reads 0x00, the status reads 0x0 and `irq_out` is all zero.
- R2: A write with `reg_addr`=0 loads the configuration register. Reading address 0 returns it. Bit 0 enables battery-dead/status-change, bit 1 battery-warning, bit 2 ready, bit 3 card-detect, and bits 7:4 are the routing number.
- R3: A level change in either direction on `pin_bvd`, `pin_warn` or `pin_rdy` sets status bit 0, 1 or 2. The bit reads as 1 on address 1 after the third rising clock edge that follows the pin change.
- R4: A level change on either `pin_cd1` or `pin_cd2` sets status bit 3, with the same latency as R3.
- R5: Status bits are sticky. A write to address 1 clears each bit whose write-data bit is 1. Write-data bits that are 0 leave their status bits unchanged.
- R6: If a set event and a write-1 clear hit the same status bit in the same cycle, the bit stays 1.
- R7: `irq_out` is a register. One edge after any status bit and its effective enable are both 1, `irq_out` has bit R set, where R is the routing number, and every other bit clear. If R is 0, `irq_out` stays all zero. `irq_out` is never more than one-hot.
- R8: While `io_mode` is 1, enable bits 1 and 2 have no effect on `irq_out`. Status bits 1 and 2 still latch changes.
- R9: A one-cycle `sw_rst` pulse clears the status register. It also clears the configuration when `wake_en` is 0. When `wake_en` is 1 the configuration is kept unchanged. Register writes in the `sw_rst` cycle are ignored.
- R10: `irq_out` returns to zero on the edge after the one that clears the last set-and-enabled status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| sw_rst | input | 1 | Synchronous software power-state reset pulse |
| wake_en | input | 1 | Power-management wake enable; preserves configuration across `sw_rst` |
| io_mode | input | 1 | 1 = I/O card interface mode, 0 = memory mode |
| pin_bvd | input | 1 | Battery-dead/status-change pin (asynchronous) |
| pin_warn | input | 1 | Battery-warning pin (asynchronous) |
| pin_rdy | input | 1 | Ready pin (asynchronous) |
| pin_cd1 | input | 1 | First card-detect pin (asynchronous) |
| pin_cd2 | input | 1 | Second card-detect pin (asynchronous) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = configuration, 1 = status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational); status is zero-extended |
| irq_out | output | 16 | One-hot management interrupt lines |

## Verification
A wrong internal state shows at the ports in one of three ways:
- A missed or spurious change event shows in the status read-back three edges after the pin moves, and on `irq_out` one edge later.
- A wrong enable, I/O-mode mask or routing decode shows as the wrong `irq_out` line, or no line, four edges after the pin change.
- A status bit that fails to clear shows on `irq_out` one edge past the clearing write, and a configuration lost or kept by mistake across `sw_rst` shows on the next read of address 0.

The sweep goes over every source pin, every enable mask, every routing number and both interface modes. This exposes any of these faults within a handful of cycles of the stimulus that triggers it.

// File: rtl/sock_irq_pkg.sv
package sock_irq_pkg;
   localparam int SRC_BVD  = 0;
   localparam int SRC_WARN = 1;
   localparam int SRC_RDY  = 2;
   localparam int SRC_CD   = 3;
   localparam int N_SRC    = 4;
   localparam int N_PIN    = 5;

   typedef enum logic {
      ADDR_CFG = 1'b0,
      ADDR_STS = 1'b1
   } reg_addr_e;

   // Enables that stay active in the given interface mode.
   function automatic logic [N_SRC-1:0] mode_mask(input logic io);
      logic [N_SRC-1:0] m;
      m = '1;
      if (io) begin
         m[SRC_WARN] = 1'b0;
         m[SRC_RDY]  = 1'b0;
      end
      return m;
   endfunction
endpackage

// File: rtl/sock_irq_sync.sv
module sock_irq_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("sock_irq_sync: STAGES must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sock_irq_edge.sv
module sock_irq_edge #(
   parameter int WIDTH = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] smp,
   output logic [WIDTH-1:0] chg
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else prev_q <= smp;
   end

   assign chg = smp ^ prev_q;
endmodule

// File: rtl/sock_irq_cfg.sv
module sock_irq_cfg #(
   parameter int CFG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_rst,
   input  logic             wake_en,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] cfg_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (sw_rst) begin
         if (!wake_en) cfg_q <= '0;
      end else if (wr_en) begin
         cfg_q <= wdata;
      end
   end
endmodule

// File: rtl/sock_irq_sts.sv
module sock_irq_sts #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sw_rst,
   input  logic [N-1:0] set_ev,
   input  logic [N-1:0] clr_mask,
   output logic [N-1:0] sts_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q <= '0;
      else if (sw_rst) sts_q <= '0;
      else sts_q <= (sts_q & ~clr_mask) | set_ev;
   end
endmodule

// File: rtl/sock_irq_route.sv
module sock_irq_route #(
   parameter int ROUTE_W = 4,
   localparam int LINES  = 1 << ROUTE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pending,
   input  logic [ROUTE_W-1:0] route,
   output logic [LINES-1:0]   irq_q
);
   logic [LINES-1:0] irq_d;

   assign irq_d[0] = 1'b0;
   for (genvar j = 1; j < LINES; j++) begin : g_line
      assign irq_d[j] = pending && (route == ROUTE_W'(j));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= '0;
      else irq_q <= irq_d;
   end
endmodule

// File: rtl/sock_irq_ctrl.sv
module sock_irq_ctrl
   import sock_irq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int ROUTE_W     = 4,
   parameter int DATA_W      = 8,
   localparam int CFG_W      = N_SRC + ROUTE_W,
   localparam int LINES      = 1 << ROUTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_rst,
   input  logic              wake_en,
   input  logic              io_mode,
   input  logic              pin_bvd,
   input  logic              pin_warn,
   input  logic              pin_rdy,
   input  logic              pin_cd1,
   input  logic              pin_cd2,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [LINES-1:0]  irq_out
);
   if (DATA_W < CFG_W) begin : g_bad_width
      $error("sock_irq_ctrl: DATA_W too narrow for configuration");
   end

   logic [N_PIN-1:0] pins, pins_s, pin_chg;
   logic [N_SRC-1:0] set_ev, clr_mask, sts_q, eff_en;
   logic [CFG_W-1:0] cfg_q;
   logic             cfg_wr, sts_wr, pending;

   assign pins = {pin_cd2, pin_cd1, pin_rdy, pin_warn, pin_bvd};

   sock_irq_sync #(.WIDTH(N_PIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pins), .q(pins_s));

   sock_irq_edge #(.WIDTH(N_PIN)) u_edge (
      .clk(clk), .rst_n(rst_n), .smp(pins_s), .chg(pin_chg));

   assign set_ev[SRC_BVD]  = pin_chg[0];
   assign set_ev[SRC_WARN] = pin_chg[1];
   assign set_ev[SRC_RDY]  = pin_chg[2];
   assign set_ev[SRC_CD]   = pin_chg[3] | pin_chg[4];

   assign cfg_wr   = reg_wr && (reg_addr == ADDR_CFG);
   assign sts_wr   = reg_wr && (reg_addr == ADDR_STS);
   assign clr_mask = sts_wr ? reg_wdata[N_SRC-1:0] : '0;

   sock_irq_cfg #(.CFG_W(CFG_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .wake_en(wake_en),
      .wr_en(cfg_wr), .wdata(reg_wdata[CFG_W-1:0]), .cfg_q(cfg_q));

   sock_irq_sts #(.N(N_SRC)) u_sts (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .set_ev(set_ev),
      .clr_mask(clr_mask), .sts_q(sts_q));

   assign eff_en  = cfg_q[N_SRC-1:0] & mode_mask(io_mode);
   assign pending = |(sts_q & eff_en);

   sock_irq_route #(.ROUTE_W(ROUTE_W)) u_route (
      .clk(clk), .rst_n(rst_n), .pending(pending),
      .route(cfg_q[CFG_W-1:N_SRC]), .irq_q(irq_out));

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_CFG) reg_rdata[CFG_W-1:0] = cfg_q;
      else reg_rdata[N_SRC-1:0] = sts_q;
   end
endmodule

// File: rtl/sock_irq_chk.sv
module sock_irq_chk #(
   parameter int ROUTE_W = 4,
   parameter int DATA_W  = 8,
   localparam int NS     = 4,
   localparam int CFG_W  = NS + ROUTE_W,
   localparam int LINES  = 1 << ROUTE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sw_rst,
   input logic              wake_en,
   input logic              io_mode,
   input logic              reg_wr,
   input logic              reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [CFG_W-1:0]  cfg_q,
   input logic [NS-1:0]     sts_q,
   input logic [LINES-1:0]  irq_out
);
   logic [NS-1:0] live_en;
   assign live_en = cfg_q[NS-1:0] & (io_mode ? 4'b1001 : 4'b1111);

   // R9
   cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_rst && wake_en) |=> $stable(cfg_q));
   // R9
   cfg_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_rst && !wake_en) |=> (cfg_q == '0));
   // R7
   irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_out));
   // R7
   irq_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[CFG_W-1:NS] == '0) |=> (irq_out == '0));
   // R5
   sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_rst && !(reg_wr && reg_addr)) |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
   // R10
   irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sts_q & live_en) == '0) |=> (irq_out == '0));
endmodule

bind sock_irq_ctrl sock_irq_chk #(.ROUTE_W(ROUTE_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .wake_en(wake_en),
   .io_mode(io_mode), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .cfg_q(cfg_q), .sts_q(sts_q), .irq_out(irq_out));

// File: tb/sock_irq_ctrl_test.sv
`timescale 1ns/1ps
module sock_irq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_rst = 1'b0, wake_en = 1'b0, io_mode = 1'b0;
   logic [4:0]  pv = '0;
   logic        reg_wr = 1'b0, reg_addr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [15:0] irq_out;
   int          n_chk = 0, n_bad = 0;
   bit          done = 0;

   always #4 clk = ~clk;

   sock_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .wake_en(wake_en),
      .io_mode(io_mode), .pin_bvd(pv[0]), .pin_warn(pv[1]), .pin_rdy(pv[2]),
      .pin_cd1(pv[3]), .pin_cd2(pv[4]), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out));

   task automatic tick(input int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      tick();
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   function automatic logic [7:0] rd(input logic a);
      reg_addr = a;
      return reg_rdata;
   endfunction

   task automatic read_chk(input string req, input logic a, input logic [7:0] exp);
      reg_addr = a;
      #1;
      check(req, {24'h0, reg_rdata}, {24'h0, exp});
   endtask

   function automatic logic [15:0] exp_irq(input logic [3:0] sts, input logic [7:0] cfg,
                                          input logic io);
      logic [3:0] en;
      en = cfg[3:0] & (io ? 4'b1001 : 4'b1111);
      if (((sts & en) != 0) && (cfg[7:4] != 0)) return 16'h1 << cfg[7:4];
      return 16'h0;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [3:0] sb;
      tick(3);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      read_chk("R1 cfg", 1'b0, 8'h00);
      read_chk("R1 sts", 1'b1, 8'h00);
      check("R1 irq", {16'h0, irq_out}, 32'h0);

      // R2 read-back
      wr(1'b0, 8'h5A);
      read_chk("R2 cfg readback", 1'b0, 8'h5A);
      wr(1'b0, 8'h00);

      // R3 R4 R7 R8 R10 sweep: pin x mode x route x enable mask
      for (int io = 0; io < 2; io++) begin
         io_mode = io[0];
         for (int p = 0; p < 5; p++) begin
            sb = 4'h1 << ((p < 4) ? p : 3);
            for (int c = 0; c < 256; c++) begin
               wr(1'b0, c[7:0]);
               pv[p] = ~pv[p];
               tick(3);
               read_chk((p >= 3) ? "R4 cd status" : "R3 status", 1'b1, {4'h0, sb});
               tick();
               check(io ? "R8 irq io mode" : "R7 irq",
                     {16'h0, irq_out}, {16'h0, exp_irq(sb, c[7:0], io[0])});
               wr(1'b1, 8'h0F);
               check("R10 irq one edge after clear", {16'h0, irq_out},
                     {16'h0, exp_irq(sb, c[7:0], io[0])});
               tick();
               check("R10 irq released", {16'h0, irq_out}, 32'h0);
               read_chk("R5 cleared", 1'b1, 8'h00);
            end
         end
      end
      io_mode = 1'b0;

      // R5 write 0 keeps, partial clear
      pv[0] = ~pv[0]; pv[2] = ~pv[2];
      tick(3);
      wr(1'b1, 8'h00);
      read_chk("R5 write zero keeps", 1'b1, 8'h05);
      wr(1'b1, 8'h04);
      read_chk("R5 partial clear", 1'b1, 8'h01);

      // R6 set and clear on the same edge: set wins
      pv[0] = ~pv[0];
      tick(2);
      wr(1'b1, 8'h01);
      read_chk("R6 set wins", 1'b1, 8'h01);
      wr(1'b1, 8'h0F);
      read_chk("R6 later clear", 1'b1, 8'h00);

      // R9 software reset with wake enabled keeps configuration
      wr(1'b0, 8'hA1);
      pv[0] = ~pv[0];
      tick(4);
      check("R9 irq before sw_rst", {16'h0, irq_out}, 32'h400);
      wake_en = 1'b1; sw_rst = 1'b1; reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h33;
      tick();
      sw_rst = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
      read_chk("R9 cfg kept", 1'b0, 8'hA1);
      read_chk("R9 sts cleared", 1'b1, 8'h00);
      tick();
      check("R9 irq after sw_rst", {16'h0, irq_out}, 32'h0);
      wake_en = 1'b0; sw_rst = 1'b1;
      tick();
      sw_rst = 1'b0;
      read_chk("R9 cfg wiped", 1'b0, 8'h00);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule